// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the effective memory address for a load/store instruction set that offers many addressing modes. Each request carries a mode, an access size, the value of the base register with its index, the destination register index, R0, the global base register, the PC and an 8-bit displacement field. The block returns the memory address with its direction and size. Where the mode asks for it, the block also returns the new value of the base register, or a computed value for R0.

Post-increment and pre-decrement forms return a base-register update. The move-address form produces no memory access and returns an address for R0. The byte logic operations relative to the global base register use a read-modify-write. For these the block issues a read and then, on the next cycle, a write to the same held address. It stalls new requests while the write phase is pending.

All outputs are registered. They appear one cycle after the request is accepted.

Top module: `lsu_agu`

## Requirements
- R1: Size codes are byte=0, word=1, long=2. Code 3 is treated as long. In displacement mode (code 1) the address is base + (disp[3:0] × 1, 2 or 4 by size), and the access direction follows req_write.
- R2: Pre-decrement mode (code 2) is always a store at base − size bytes. It also updates the base register to that same value.
- R3: Post-increment mode (code 3) is always a load at the old base. It updates the base register to base + size bytes.
- R4: In post-increment mode the base update is suppressed when req_dst_idx equals req_base_idx, so the loaded value wins.
- R5: Indexed mode (code 4) addresses base + R0, with no displacement, and follows req_write.
- R6: PC-relative mode (code 5) is a load at PC + 4 + disp × size bytes. For long accesses the low two address bits are cleared.
- R7: Move-address mode (code 7) writes (PC with low two bits cleared) + 4 + 4 × disp to R0. It makes no memory access and no base update.
- R8: Global-base displacement mode (code 6) addresses the global base + the unscaled 8-bit disp, and follows req_write.
- R9: Global-base indexed modes address global base + R0 with byte size. Test (code 8) is a single read. Read-modify-write (code 9) gives a read, then a write to the same address on the next cycle with mem_rmw_wb=1. req_ready is low during the read cycle, and a request offered then is ignored.
- R10: All address and update arithmetic wraps modulo 2^32.
- R11: Outputs appear one cycle after the clock edge that accepts a request. Reset clears all valid and enable outputs and sets req_ready.
- R12: Register-indirect mode (code 0) addresses the base value unchanged, and follows req_write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_mode | input | 4 | Addressing mode code |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | Store when set (modes 0, 1, 4, 6) |
| req_base | input | 32 | Base register value |
| req_base_idx | input | 4 | Base register index |
| req_dst_idx | input | 4 | Load destination register index |
| req_r0 | input | 32 | R0 value |
| req_gbr | input | 32 | Global base register value |
| req_pc | input | 32 | Instruction address |
| req_disp | input | 8 | Displacement field |
| mem_valid | output | 1 | Memory access issued |
| mem_addr | output | 32 | Effective address |
| mem_write | output | 1 | Access is a store |
| mem_size | output | 2 | Access size code |
| mem_rmw_wb | output | 1 | Write phase of a read-modify-write |
| base_upd_en | output | 1 | Base register update |
| base_upd_idx | output | 4 | Register to update |
| base_upd_value | output | 32 | New base value |
| r0_wr_en | output | 1 | Write R0 (move-address) |
| r0_wr_value | output | 32 | Value for R0 |

## Verification
A wrong scale shift or a missing alignment mask shows up as a wrong mem_addr in the cycle after acceptance. Sweeping every mode against low, mid and wrapping base values exposes such errors at once. A lost pending flag in the read-modify-write sequence shows within two cycles, in one of three ways: the write phase goes missing, the write address is not held, or a request offered while stalled is accepted. The post-increment ordering rule is covered by sweeping both equal and different register indices.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [3:0] {
        M_IND     = 4'd0,
        M_DISP    = 4'd1,
        M_PREDEC  = 4'd2,
        M_POSTINC = 4'd3,
        M_IDX     = 4'd4,
        M_PCREL   = 4'd5,
        M_GBRD    = 4'd6,
        M_MOVA    = 4'd7,
        M_GTST    = 4'd8,
        M_GRMW    = 4'd9
    } agu_mode_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_L = 2'd2,
        SZ_X = 2'd3
    } agu_size_e;

    typedef struct packed {
        logic mem;
        logic wr;
        logic upd;
        logic r0w;
        logic rmw;
        logic postinc;
    } agu_ctl_t;

    function automatic logic [1:0] size_shift(input logic [1:0] sz);
        case (sz)
            SZ_B:    return 2'd0;
            SZ_W:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        return 3'd1 << size_shift(sz);
    endfunction

endpackage

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 8,
    parameter int SDW = 4
) (
    input  logic [3:0]    mode,
    input  logic [1:0]    size,
    input  logic          write,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] r0,
    input  logic [AW-1:0] gbr,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] upd_val,
    output logic [AW-1:0] r0_val,
    output logic [1:0]    eff_size,
    output agu_ctl_t      ctl
);
    localparam int PAD_D = AW - DW;
    localparam int PAD_S = AW - SDW;
    localparam int PAD_B = AW - 3;

    logic [AW-1:0] disp_ext, sdisp_ext, step, pc_plus4, pc_aligned;
    logic [1:0]    sh;

    assign sh         = size_shift(size);
    assign disp_ext   = {{PAD_D{1'b0}}, disp};
    assign sdisp_ext  = {{PAD_S{1'b0}}, disp[SDW-1:0]};
    assign step       = {{PAD_B{1'b0}}, size_bytes(size)};
    assign pc_plus4   = pc + AW'(4);
    assign pc_aligned = {pc[AW-1:2], 2'b00};

    always_comb begin
        addr     = base;
        upd_val  = base;
        r0_val   = '0;
        eff_size = size;
        ctl      = '{mem: 1'b1, wr: write, upd: 1'b0, r0w: 1'b0, rmw: 1'b0, postinc: 1'b0};
        case (agu_mode_e'(mode))
            M_IND:   addr = base;
            M_DISP:  addr = base + (sdisp_ext << sh);
            M_PREDEC: begin
                addr    = base - step;
                upd_val = base - step;
                ctl.wr  = 1'b1;
                ctl.upd = 1'b1;
            end
            M_POSTINC: begin
                addr        = base;
                upd_val     = base + step;
                ctl.wr      = 1'b0;
                ctl.upd     = 1'b1;
                ctl.postinc = 1'b1;
            end
            M_IDX:   addr = base + r0;
            M_PCREL: begin
                addr   = pc_plus4 + (disp_ext << sh);
                ctl.wr = 1'b0;
                if (sh == 2'd2) addr[1:0] = 2'b00;
            end
            M_GBRD:  addr = gbr + disp_ext;
            M_MOVA: begin
                ctl.mem = 1'b0;
                ctl.wr  = 1'b0;
                ctl.r0w = 1'b1;
                r0_val  = pc_aligned + AW'(4) + (disp_ext << 2);
            end
            M_GTST: begin
                addr     = gbr + r0;
                ctl.wr   = 1'b0;
                eff_size = SZ_B;
            end
            M_GRMW: begin
                addr     = gbr + r0;
                ctl.wr   = 1'b0;
                ctl.rmw  = 1'b1;
                eff_size = SZ_B;
            end
            default: begin
                ctl.mem = 1'b0;
                ctl.wr  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/agu_wb_ctrl.sv
module agu_wb_ctrl
    import agu_pkg::*;
#(
    parameter int RW = 4
) (
    input  agu_ctl_t      ctl,
    input  logic [RW-1:0] dst_idx,
    input  logic [RW-1:0] base_idx,
    output logic          upd_en
);
    logic same_reg;
    assign same_reg = (dst_idx == base_idx);
    // a load into the incremented base keeps the loaded value
    assign upd_en   = ctl.upd && !(ctl.postinc && same_reg);
endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
#(
    parameter int AW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  agu_ctl_t      ctl,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_val,
    input  logic [RW-1:0] upd_idx,
    input  logic [AW-1:0] r0_val,
    output logic          pending,
    output logic          o_valid,
    output logic [AW-1:0] o_addr,
    output logic          o_write,
    output logic [1:0]    o_size,
    output logic          o_rmw_wb,
    output logic          o_upd_en,
    output logic [RW-1:0] o_upd_idx,
    output logic [AW-1:0] o_upd_val,
    output logic          o_r0_en,
    output logic [AW-1:0] o_r0_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            o_valid   <= 1'b0;
            o_addr    <= '0;
            o_write   <= 1'b0;
            o_size    <= '0;
            o_rmw_wb  <= 1'b0;
            o_upd_en  <= 1'b0;
            o_upd_idx <= '0;
            o_upd_val <= '0;
            o_r0_en   <= 1'b0;
            o_r0_val  <= '0;
        end else if (pending) begin
            // write phase: address and size held from the read phase
            pending  <= 1'b0;
            o_valid  <= 1'b1;
            o_write  <= 1'b1;
            o_rmw_wb <= 1'b1;
            o_upd_en <= 1'b0;
            o_r0_en  <= 1'b0;
        end else if (accept) begin
            pending   <= ctl.rmw;
            o_valid   <= ctl.mem;
            o_addr    <= addr;
            o_write   <= ctl.wr;
            o_size    <= size;
            o_rmw_wb  <= 1'b0;
            o_upd_en  <= upd_en;
            o_upd_idx <= upd_idx;
            o_upd_val <= upd_val;
            o_r0_en   <= ctl.r0w;
            o_r0_val  <= r0_val;
        end else begin
            o_valid  <= 1'b0;
            o_rmw_wb <= 1'b0;
            o_upd_en <= 1'b0;
            o_r0_en  <= 1'b0;
        end
    end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
    import agu_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 8,
    parameter int SDW = 4,
    parameter int RW  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_mode,
    input  logic [1:0]    req_size,
    input  logic          req_write,
    input  logic [AW-1:0] req_base,
    input  logic [RW-1:0] req_base_idx,
    input  logic [RW-1:0] req_dst_idx,
    input  logic [AW-1:0] req_r0,
    input  logic [AW-1:0] req_gbr,
    input  logic [AW-1:0] req_pc,
    input  logic [DW-1:0] req_disp,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_write,
    output logic [1:0]    mem_size,
    output logic          mem_rmw_wb,
    output logic          base_upd_en,
    output logic [RW-1:0] base_upd_idx,
    output logic [AW-1:0] base_upd_value,
    output logic          r0_wr_en,
    output logic [AW-1:0] r0_wr_value
);
    agu_ctl_t      c_ctl;
    logic [AW-1:0] c_addr, c_upd, c_r0;
    logic [1:0]    c_size;
    logic          c_upd_en, pending;

    agu_addr_calc #(.AW(AW), .DW(DW), .SDW(SDW)) u_calc (
        .mode(req_mode), .size(req_size), .write(req_write),
        .base(req_base), .r0(req_r0), .gbr(req_gbr), .pc(req_pc),
        .disp(req_disp), .addr(c_addr), .upd_val(c_upd), .r0_val(c_r0),
        .eff_size(c_size), .ctl(c_ctl)
    );

    agu_wb_ctrl #(.RW(RW)) u_wb (
        .ctl(c_ctl), .dst_idx(req_dst_idx), .base_idx(req_base_idx),
        .upd_en(c_upd_en)
    );

    agu_seq #(.AW(AW), .RW(RW)) u_seq (
        .clk(clk), .rst(rst), .accept(req_valid && req_ready),
        .ctl(c_ctl), .addr(c_addr), .size(c_size), .upd_en(c_upd_en),
        .upd_val(c_upd), .upd_idx(req_base_idx), .r0_val(c_r0),
        .pending(pending), .o_valid(mem_valid), .o_addr(mem_addr),
        .o_write(mem_write), .o_size(mem_size), .o_rmw_wb(mem_rmw_wb),
        .o_upd_en(base_upd_en), .o_upd_idx(base_upd_idx),
        .o_upd_val(base_upd_value), .o_r0_en(r0_wr_en), .o_r0_val(r0_wr_value)
    );

    assign req_ready = !pending;
endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          mem_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_write,
    input logic [1:0]    mem_size,
    input logic          mem_rmw_wb,
    input logic          base_upd_en,
    input logic [AW-1:0] base_upd_value,
    input logic          r0_wr_en
);
    logic [AW-1:0] step;
    assign step = (mem_size == 2'd0) ? AW'(1) : (mem_size == 2'd1) ? AW'(2) : AW'(4);

    p_rmw_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_write && !req_ready) |=>
        (mem_valid && mem_write && mem_rmw_wb && $stable(mem_addr)));

    p_rmw_byte_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rmw_wb |-> (mem_size == 2'd0 && req_ready));

    p_mova_nomem_r7: assert property (@(posedge clk) disable iff (rst)
        r0_wr_en |-> (!mem_valid && !base_upd_en));

    p_predec_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (base_upd_en && mem_write) |-> (base_upd_value == mem_addr));

    p_postinc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (base_upd_en && !mem_write) |-> (base_upd_value - mem_addr == step));

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!mem_valid && !base_upd_en && !r0_wr_en && req_ready));
endmodule

bind lsu_agu lsu_agu_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_write(mem_write), .mem_size(mem_size),
    .mem_rmw_wb(mem_rmw_wb), .base_upd_en(base_upd_en),
    .base_upd_value(base_upd_value), .r0_wr_en(r0_wr_en)
);

// File: tb/lsu_agu_tb.sv
module lsu_agu_tb;
    import agu_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_mode = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_base = '0, req_r0 = '0, req_gbr = '0, req_pc = '0;
    logic [3:0]  req_base_idx = '0, req_dst_idx = '0;
    logic [7:0]  req_disp = '0;
    logic        mem_valid, mem_write, mem_rmw_wb, base_upd_en, r0_wr_en;
    logic [31:0] mem_addr, base_upd_value, r0_wr_value;
    logic [1:0]  mem_size;
    logic [3:0]  base_upd_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    lsu_agu u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_size(req_size), .req_write(req_write),
        .req_base(req_base), .req_base_idx(req_base_idx), .req_dst_idx(req_dst_idx),
        .req_r0(req_r0), .req_gbr(req_gbr), .req_pc(req_pc), .req_disp(req_disp),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
        .mem_size(mem_size), .mem_rmw_wb(mem_rmw_wb), .base_upd_en(base_upd_en),
        .base_upd_idx(base_upd_idx), .base_upd_value(base_upd_value),
        .r0_wr_en(r0_wr_en), .r0_wr_value(r0_wr_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [3:0] m, input bit same);
        case (agu_mode_e'(m))
            M_IND:     return "R12";
            M_DISP:    return "R1";
            M_PREDEC:  return "R2";
            M_POSTINC: return same ? "R4" : "R3";
            M_IDX:     return "R5";
            M_PCREL:   return "R6";
            M_GBRD:    return "R8";
            M_MOVA:    return "R7";
            default:   return "R9";
        endcase
    endfunction

    // drive at a falling edge, accepted on the next rising edge, sampled at the following falling edge
    task automatic run_one(input logic [3:0] m, input logic [1:0] sz, input logic wr,
                           input logic [31:0] base, input logic [31:0] r0,
                           input logic [31:0] gbr, input logic [31:0] pc,
                           input logic [7:0] disp, input logic [3:0] dst,
                           input logic [3:0] bidx);
        logic [31:0] nb, a, uv, rv;
        logic v, w, ue, re;
        logic [1:0] es;
        string tag;
        nb = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        a = base; uv = '0; rv = '0; v = 1'b1; w = wr; ue = 1'b0; re = 1'b0; es = sz;
        case (agu_mode_e'(m))
            M_IND:     a = base;
            M_DISP:    a = base + 32'(disp[3:0]) * nb;
            M_PREDEC:  begin a = base - nb; w = 1'b1; ue = 1'b1; uv = base - nb; end
            M_POSTINC: begin a = base; w = 1'b0; ue = (dst != bidx); uv = base + nb; end
            M_IDX:     a = base + r0;
            M_PCREL:   begin
                a = pc + 32'd4 + 32'(disp) * nb; w = 1'b0;
                if (nb == 32'd4) a = a & 32'hFFFF_FFFC;
            end
            M_GBRD:    a = gbr + 32'(disp);
            M_MOVA:    begin v = 1'b0; w = 1'b0; re = 1'b1;
                             rv = (pc & 32'hFFFF_FFFC) + 32'd4 + 32'(disp) * 32'd4; end
            default:   begin a = gbr + r0; w = 1'b0; es = 2'd0; end
        endcase
        tag = mode_tag(m, dst == bidx);
        req_valid = 1'b1; req_mode = m; req_size = sz; req_write = wr;
        req_base = base; req_r0 = r0; req_gbr = gbr; req_pc = pc; req_disp = disp;
        req_dst_idx = dst; req_base_idx = bidx;
        @(posedge clk); @(negedge clk);
        check(tag, "mem_valid", 32'(mem_valid), 32'(v));
        check(tag, "r0_wr_en", 32'(r0_wr_en), 32'(re));
        check(tag, "base_upd_en", 32'(base_upd_en), 32'(ue));
        if (v) begin
            check(tag, "mem_addr", mem_addr, a);
            check(tag, "mem_write", 32'(mem_write), 32'(w));
            check(tag, "mem_size", 32'(mem_size), 32'(es));
        end
        if (ue) begin
            check(tag, "base_upd_value", base_upd_value, uv);
            check(tag, "base_upd_idx", 32'(base_upd_idx), 32'(bidx));
        end
        if (re) check(tag, "r0_wr_value", r0_wr_value, rv);
        if (agu_mode_e'(m) == M_GRMW) begin
            check("R9", "ready low in read phase", 32'(req_ready), 32'd0);
            // offered while stalled: must be ignored
            req_mode = M_IND; req_base = 32'h0000_5555; req_write = 1'b1;
            @(posedge clk); @(negedge clk);
            check("R9", "wb valid", 32'(mem_valid), 32'd1);
            check("R9", "wb write", 32'(mem_write), 32'd1);
            check("R9", "wb flag", 32'(mem_rmw_wb), 32'd1);
            check("R9", "wb addr held", mem_addr, a);
            check("R9", "ready back", 32'(req_ready), 32'd1);
            req_valid = 1'b0;
            @(posedge clk); @(negedge clk);
            check("R9", "stalled request ignored", 32'(mem_valid), 32'd0);
        end else begin
            check(tag, "no rmw flag", 32'(mem_rmw_wb), 32'd0);
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                done = 1;
                failures++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] bases [3];
        logic [7:0]  disps [4];
        bases[0] = 32'h0000_1000; bases[1] = 32'h0000_0002; bases[2] = 32'hFFFF_FFFD;
        disps[0] = 8'h00; disps[1] = 8'h07; disps[2] = 8'h0F; disps[3] = 8'hFF;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", "reset mem_valid", 32'(mem_valid), 32'd0);
        check("R11", "reset base_upd_en", 32'(base_upd_en), 32'd0);
        check("R11", "reset r0_wr_en", 32'(r0_wr_en), 32'd0);
        check("R11", "reset ready", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);

        for (int m = 0; m < 10; m++)
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 3; b++)
                    for (int d = 0; d < 4; d++)
                        for (int k = 0; k < 2; k++)
                            run_one(4'(m), 2'(s), k[0], bases[b], bases[b] << 1,
                                    32'hFFFF_FF80 + 32'(b), bases[b] + 32'd1,
                                    disps[d], k[0] ? 4'd5 : 4'd6, 4'd5);

        // R10: wrap below zero and above the top
        run_one(M_PREDEC, 2'd2, 1'b0, 32'h0000_0000, '0, '0, '0, 8'h00, 4'd1, 4'd2);
        run_one(M_POSTINC, 2'd2, 1'b0, 32'hFFFF_FFFE, '0, '0, '0, 8'h00, 4'd1, 4'd2);
        check("R10", "wrapped increment", base_upd_value, 32'h0000_0002);

        // R11: idle after valid drops
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11", "idle no access", 32'(mem_valid), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule